// File: doc/BRIEF.md
# Ethernet Wakeup Status and Interrupt

This block keeps the power-management wakeup status of an Ethernet MAC. Two sticky flags, one for a received magic packet and one for a received wakeup frame, are set by single-cycle detect pulses from the receive clock domain. The pattern matcher and the magic packet detector sit outside the block. The flags are stored in receive-domain flops. They drive a level line to an external edge-sensitive interrupt controller. Synchronized copies of the flags drive a dedicated wakeup interrupt in the bus clock domain. This interrupt is separate from the ordinary MAC and DMA interrupt.

Software reads one control/status register on the bus clock. That register holds a detection enable for each source, a global interrupt enable, the two synchronized flags and a busy bit for the clear handshake. A read strobe clears both flags. The clear request travels to the receive domain as a toggle, and the acknowledge toggle comes back through a synchronizer. While the clear is in flight, the flags and the interrupt remain visible for a few receive-clock cycles after the read. Firmware therefore polls until the flags read back as zero.

Top module: `pmt_wake_status`

## Requirements
- R1: After reset, csr_rdata is all zero and wake_irq and wake_event are low.
- R2: A det_frame pulse while the frame enable (csr bit 1) is 1 sets the frame flag. The flag appears at csr_rdata bit 6 after the bus synchronizer.
- R3: A det_magic pulse while the magic enable (csr bit 0) is 1 sets the magic flag. The flag appears at csr_rdata bit 5 after the bus synchronizer.
- R4: A detect pulse whose source enable is 0 is ignored. The flag, wake_event and wake_irq all stay low.
- R5: A set flag stays set for as long as no clear is performed.
- R6: A csr_rd strobe while csr_rdata bit 7 (clear busy) is 0 starts a clear of both flags. Once bit 7 returns to 0, bits 5 and 6 read 0.
- R7: wake_irq is registered and equals the global interrupt enable (csr bit 2) ANDed with the OR of csr_rdata bits 5 and 6 from the previous bus cycle.
- R8: wake_irq and bit 7 are still 1 in the bus cycle that follows a clearing read. Both fall within 8 receive-clock periods.
- R9: A csr_rd strobe while bit 7 is 1 starts no new clear, and bit 7 stays 1.
- R10: wake_event rises one receive-clock edge after an enabled detect pulse. It stays high while either flag is set and falls when the clear takes effect.
- R11: With SET_WINS=1, a detect pulse in the same receive cycle as the clear leaves its flag set.
- R12: A csr_wr strobe loads the magic enable, frame enable and interrupt enable from csr_wdata bits 0, 1 and 2. These bits read back at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| csr_wr | input | 1 | Write strobe for the enable bits |
| csr_rd | input | 1 | Read strobe; starts a clear of the flags |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Control/status read value |
| wake_irq | output | 1 | Wakeup interrupt, bus domain |
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Asynchronous active-low reset, receive domain |
| det_frame | input | 1 | Wakeup frame detect pulse, one rx_clk cycle |
| det_magic | input | 1 | Magic packet detect pulse, one rx_clk cycle |
| wake_event | output | 1 | Level line to the external edge-sensitive controller |

## Verification
The receive-domain properties assume the following about the inputs:
- det_frame and det_magic change only between receive-clock edges.
- The enables have settled through their synchronizer before a pulse that depends on them arrives.

The stimulus drives every detect pulse on a falling receive-clock edge. After each enable write it waits several receive periods before it pulses a detector.

The bus-side properties assume that csr_rd is a clean strobe sampled on the bus clock. The bench issues reads only on falling bus-clock edges.

The set-priority check holds det_frame high across a whole clear. This makes a detect pulse coincide with the clear cycle without any need to align the two clocks.

// File: rtl/pmt_wake_pkg.sv
package pmt_wake_pkg;

   localparam int WK_NUM_SRC    = 2;
   localparam int WK_SRC_MAGIC  = 0;
   localparam int WK_SRC_FRAME  = 1;

   localparam int CSR_MAGIC_EN  = 0;
   localparam int CSR_FRAME_EN  = 1;
   localparam int CSR_IRQ_EN    = 2;
   localparam int CSR_MAGIC_HIT = 5;
   localparam int CSR_FRAME_HIT = 6;
   localparam int CSR_CLR_BUSY  = 7;
   localparam int CSR_MIN_W     = 8;

   typedef struct packed {
      logic                  irq_en;
      logic [WK_NUM_SRC-1:0] det_en;
   } wk_ctrl_t;

endpackage

// File: rtl/pmt_wake_sync.sv
module pmt_wake_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pmt_wake_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pmt_wake_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pmt_wake_clr_req.sv
module pmt_wake_clr_req (
   input  logic clk,
   input  logic rst_n,
   input  logic rd,
   input  logic ack_tgl_s,
   output logic req_tgl,
   output logic busy
);
   logic req_q;

   assign busy    = req_q ^ ack_tgl_s;
   assign req_tgl = req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          req_q <= 1'b0;
      else if (rd && !busy) req_q <= ~req_q;
   end
endmodule

// File: rtl/pmt_wake_clr_rsp.sv
module pmt_wake_clr_rsp (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   output logic clr_hit,
   output logic ack_tgl
);
   logic seen_q;

   assign clr_hit = req_s ^ seen_q;
   assign ack_tgl = seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= req_s;
   end
endmodule

// File: rtl/pmt_wake_flags.sv
module pmt_wake_flags #(
   parameter int NUM_SRC  = 2,
   parameter bit SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] det,
   input  logic [NUM_SRC-1:0] en,
   input  logic               clr,
   output logic [NUM_SRC-1:0] flags
);
   if (NUM_SRC < 1) begin : g_bad_num
      $error("pmt_wake_flags: NUM_SRC must be at least 1");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic hit;
      logic flag_q;
      assign hit      = det[i] & en[i];
      assign flags[i] = flag_q;

      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (hit) flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (clr) flag_q <= 1'b0;
            else if (hit) flag_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pmt_wake_status.sv
module pmt_wake_status
   import pmt_wake_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SET_WINS    = 1'b1
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              csr_wr,
   input  logic              csr_rd,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   output logic              wake_irq,
   input  logic              rx_clk,
   input  logic              rx_rst_n,
   input  logic              det_frame,
   input  logic              det_magic,
   output logic              wake_event
);
   localparam int SRC_W  = WK_NUM_SRC;
   localparam int BACK_W = SRC_W + 1;

   if (DATA_W < CSR_MIN_W) begin : g_bad_data_w
      $error("pmt_wake_status: DATA_W must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pmt_wake_status: SYNC_STAGES must be at least 2");
   end

   // bus domain state
   wk_ctrl_t          ctrl_q;
   logic              req_tgl;
   logic              clr_busy;
   logic [SRC_W-1:0]  flags_bus;
   logic              ack_bus;
   logic [BACK_W-1:0] back_s;
   logic              irq_q;

   // receive domain state
   logic [SRC_W-1:0]  rx_det_en;
   logic              rx_req_s;
   logic              rx_clr_hit;
   logic              rx_ack_tgl;
   logic [SRC_W-1:0]  rx_flags;
   logic [SRC_W-1:0]  rx_det;

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         ctrl_q <= '0;
      end else if (csr_wr) begin
         ctrl_q.det_en[WK_SRC_MAGIC] <= csr_wdata[CSR_MAGIC_EN];
         ctrl_q.det_en[WK_SRC_FRAME] <= csr_wdata[CSR_FRAME_EN];
         ctrl_q.irq_en               <= csr_wdata[CSR_IRQ_EN];
      end
   end

   pmt_wake_clr_req u_clr_req (
      .clk       (bus_clk),
      .rst_n     (bus_rst_n),
      .rd        (csr_rd),
      .ack_tgl_s (ack_bus),
      .req_tgl   (req_tgl),
      .busy      (clr_busy)
   );

   pmt_wake_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_en_sync (
      .clk   (rx_clk),
      .rst_n (rx_rst_n),
      .d     (ctrl_q.det_en),
      .q     (rx_det_en)
   );

   pmt_wake_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (rx_clk),
      .rst_n (rx_rst_n),
      .d     (req_tgl),
      .q     (rx_req_s)
   );

   pmt_wake_clr_rsp u_clr_rsp (
      .clk     (rx_clk),
      .rst_n   (rx_rst_n),
      .req_s   (rx_req_s),
      .clr_hit (rx_clr_hit),
      .ack_tgl (rx_ack_tgl)
   );

   always_comb begin
      rx_det               = '0;
      rx_det[WK_SRC_MAGIC] = det_magic;
      rx_det[WK_SRC_FRAME] = det_frame;
   end

   pmt_wake_flags #(.NUM_SRC(SRC_W), .SET_WINS(SET_WINS)) u_flags (
      .clk   (rx_clk),
      .rst_n (rx_rst_n),
      .det   (rx_det),
      .en    (rx_det_en),
      .clr   (rx_clr_hit),
      .flags (rx_flags)
   );

   assign wake_event = |rx_flags;

   // flags and acknowledge change on the same rx edge, so they cross together
   pmt_wake_sync #(.WIDTH(BACK_W), .STAGES(SYNC_STAGES)) u_back_sync (
      .clk   (bus_clk),
      .rst_n (bus_rst_n),
      .d     ({rx_ack_tgl, rx_flags}),
      .q     (back_s)
   );

   assign flags_bus = back_s[SRC_W-1:0];
   assign ack_bus   = back_s[SRC_W];

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) irq_q <= 1'b0;
      else            irq_q <= ctrl_q.irq_en & (|flags_bus);
   end

   assign wake_irq = irq_q;

   always_comb begin
      csr_rdata                = '0;
      csr_rdata[CSR_MAGIC_EN]  = ctrl_q.det_en[WK_SRC_MAGIC];
      csr_rdata[CSR_FRAME_EN]  = ctrl_q.det_en[WK_SRC_FRAME];
      csr_rdata[CSR_IRQ_EN]    = ctrl_q.irq_en;
      csr_rdata[CSR_MAGIC_HIT] = flags_bus[WK_SRC_MAGIC];
      csr_rdata[CSR_FRAME_HIT] = flags_bus[WK_SRC_FRAME];
      csr_rdata[CSR_CLR_BUSY]  = clr_busy;
   end
endmodule

// File: rtl/pmt_wake_status_chk.sv
module pmt_wake_status_chk
   import pmt_wake_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit SET_WINS = 1'b1
) (
   input logic              bus_clk,
   input logic              bus_rst_n,
   input logic              rx_clk,
   input logic              rx_rst_n,
   input logic              csr_rd,
   input logic [DATA_W-1:0] csr_rdata,
   input logic              wake_irq,
   input logic              req_tgl,
   input logic              det_frame,
   input logic              det_magic,
   input logic [1:0]        en_rx,
   input logic [1:0]        flags_rx,
   input logic              clr_hit,
   input logic              wake_event
);
   // R9
   busy_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (csr_rd && csr_rdata[CSR_CLR_BUSY]) |=> $stable(req_tgl));

   // R6
   clr_start_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (csr_rd && !csr_rdata[CSR_CLR_BUSY]) |=> csr_rdata[CSR_CLR_BUSY]);

   // R7
   irq_gate_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      wake_irq |-> $past(csr_rdata[CSR_IRQ_EN] &&
                         (csr_rdata[CSR_MAGIC_HIT] || csr_rdata[CSR_FRAME_HIT])));

   // R4
   frame_off_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
      (!flags_rx[WK_SRC_FRAME] && !(det_frame && en_rx[WK_SRC_FRAME]))
      |=> !flags_rx[WK_SRC_FRAME]);

   // R4
   magic_off_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
      (!flags_rx[WK_SRC_MAGIC] && !(det_magic && en_rx[WK_SRC_MAGIC]))
      |=> !flags_rx[WK_SRC_MAGIC]);

   // R5
   sticky_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
      (flags_rx[WK_SRC_FRAME] && !clr_hit) |=> flags_rx[WK_SRC_FRAME]);

   // R10
   event_rise_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
      $rose(wake_event) |-> $past((det_frame && en_rx[WK_SRC_FRAME]) ||
                                  (det_magic && en_rx[WK_SRC_MAGIC])));

   if (SET_WINS) begin : g_set_prio
      // R11
      set_wins_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
         (det_frame && en_rx[WK_SRC_FRAME]) |=> flags_rx[WK_SRC_FRAME]);
   end
endmodule

bind pmt_wake_status pmt_wake_status_chk #(.DATA_W(DATA_W), .SET_WINS(SET_WINS)) u_chk (
   .bus_clk    (bus_clk),
   .bus_rst_n  (bus_rst_n),
   .rx_clk     (rx_clk),
   .rx_rst_n   (rx_rst_n),
   .csr_rd     (csr_rd),
   .csr_rdata  (csr_rdata),
   .wake_irq   (wake_irq),
   .req_tgl    (req_tgl),
   .det_frame  (det_frame),
   .det_magic  (det_magic),
   .en_rx      (rx_det_en),
   .flags_rx   (rx_flags),
   .clr_hit    (rx_clr_hit),
   .wake_event (wake_event)
);

// File: tb/pmt_wake_status_test.sv
`timescale 1ns/1ps
module pmt_wake_status_test;
   localparam int DW = 8;

   logic          bus_clk = 1'b0;
   logic          rx_clk  = 1'b0;
   logic          bus_rst_n = 1'b0;
   logic          rx_rst_n  = 1'b0;
   logic          csr_wr = 1'b0;
   logic          csr_rd = 1'b0;
   logic [DW-1:0] csr_wdata = '0;
   logic [DW-1:0] csr_rdata;
   logic          wake_irq;
   logic          det_frame = 1'b0;
   logic          det_magic = 1'b0;
   logic          wake_event;

   int n_checks = 0;
   int n_fail   = 0;

   always #2  bus_clk = ~bus_clk;
   always #20 rx_clk  = ~rx_clk;

   pmt_wake_status uut (
      .bus_clk    (bus_clk),
      .bus_rst_n  (bus_rst_n),
      .csr_wr     (csr_wr),
      .csr_rd     (csr_rd),
      .csr_wdata  (csr_wdata),
      .csr_rdata  (csr_rdata),
      .wake_irq   (wake_irq),
      .rx_clk     (rx_clk),
      .rx_rst_n   (rx_rst_n),
      .det_frame  (det_frame),
      .det_magic  (det_magic),
      .wake_event (wake_event)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_ctrl(input logic [2:0] v);
      @(negedge bus_clk);
      csr_wr = 1'b1; csr_wdata = {5'b0, v};
      @(negedge bus_clk);
      csr_wr = 1'b0; csr_wdata = '0;
      repeat (4) @(negedge rx_clk);
   endtask

   task automatic pulse_frame();
      @(negedge rx_clk); det_frame = 1'b1;
      @(negedge rx_clk); det_frame = 1'b0;
   endtask

   task automatic pulse_magic();
      @(negedge rx_clk); det_magic = 1'b1;
      @(negedge rx_clk); det_magic = 1'b0;
   endtask

   task automatic do_read();
      @(negedge bus_clk); csr_rd = 1'b1;
      @(negedge bus_clk); csr_rd = 1'b0;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (csr_rdata[7] && cyc < 200) begin
         @(negedge bus_clk); cyc++;
      end
   endtask

   task automatic t_reset();
      check(csr_rdata == '0, "R1 rdata", csr_rdata, 0);
      check(!wake_irq && !wake_event, "R1 outputs", {wake_irq, wake_event}, 0);
   endtask

   task automatic t_enables();
      write_ctrl(3'b111);
      check(csr_rdata[2:0] == 3'b111, "R12 enable readback", csr_rdata[2:0], 7);
      write_ctrl(3'b010);
      check(csr_rdata[2:0] == 3'b010, "R12 enable readback 2", csr_rdata[2:0], 2);
      write_ctrl(3'b111);
   endtask

   task automatic t_frame_set();
      @(negedge rx_clk); det_frame = 1'b1;
      @(negedge rx_clk); det_frame = 1'b0;
      check(wake_event == 1'b1, "R10 event rise", wake_event, 1);
      repeat (4) @(negedge bus_clk);
      check(csr_rdata[6] == 1'b1 && csr_rdata[5] == 1'b0, "R2 frame flag",
            csr_rdata[6:5], 2);
      check(wake_irq == 1'b1, "R7 irq on", wake_irq, 1);
      repeat (60) @(negedge bus_clk);
      check(csr_rdata[6] == 1'b1 && wake_event, "R5 sticky", csr_rdata[6], 1);
   endtask

   task automatic t_clear();
      int cyc;
      do_read();
      check(wake_irq == 1'b1, "R8 irq after read", wake_irq, 1);
      check(csr_rdata[7] == 1'b1, "R8 busy after read", csr_rdata[7], 1);
      wait_idle(cyc);
      check(cyc < 80, "R8 clear latency", cyc, 80);
      check(csr_rdata[6:5] == 2'b00, "R6 flags cleared", csr_rdata[6:5], 0);
      @(negedge bus_clk);
      check(!wake_irq, "R6 irq cleared", wake_irq, 0);
      check(!wake_event, "R10 event fall", wake_event, 0);
   endtask

   task automatic t_magic();
      pulse_magic();
      repeat (4) @(negedge bus_clk);
      check(csr_rdata[6:5] == 2'b01, "R3 magic flag", csr_rdata[6:5], 1);
      t_clear();
   endtask

   task automatic t_disabled();
      write_ctrl(3'b100);
      pulse_frame();
      pulse_magic();
      repeat (6) @(negedge bus_clk);
      check(csr_rdata[6:5] == 2'b00, "R4 flags ignored", csr_rdata[6:5], 0);
      check(!wake_event && !wake_irq, "R4 outputs ignored",
            {wake_event, wake_irq}, 0);
   endtask

   task automatic t_irq_gate();
      write_ctrl(3'b010);
      pulse_frame();
      repeat (6) @(negedge bus_clk);
      check(csr_rdata[6] == 1'b1, "R7 flag with irq off", csr_rdata[6], 1);
      check(!wake_irq, "R7 irq gated", wake_irq, 0);
      @(negedge bus_clk); csr_wr = 1'b1; csr_wdata = 8'h06;
      @(negedge bus_clk); csr_wr = 1'b0; csr_wdata = '0;
      @(negedge bus_clk);
      check(wake_irq == 1'b1, "R7 irq ungated", wake_irq, 1);
   endtask

   task automatic t_busy_ignore();
      int cyc;
      @(negedge bus_clk); csr_rd = 1'b1;
      @(negedge bus_clk);
      @(negedge bus_clk); csr_rd = 1'b0;
      check(csr_rdata[7] == 1'b1, "R9 busy kept", csr_rdata[7], 1);
      wait_idle(cyc);
      repeat (40) @(negedge bus_clk);
      check(csr_rdata[7:5] == 3'b000, "R9 single clear", csr_rdata[7:5], 0);
   endtask

   task automatic t_set_wins();
      int cyc;
      bit  dropped = 1'b0;
      @(negedge rx_clk); det_frame = 1'b1;
      @(negedge rx_clk);
      do_read();
      for (int k = 0; k < 10; k++) begin
         @(negedge rx_clk);
         if (!wake_event) dropped = 1'b1;
      end
      check(!dropped, "R11 event held", dropped, 0);
      wait_idle(cyc);
      check(csr_rdata[6] == 1'b1, "R11 flag kept", csr_rdata[6], 1);
      @(negedge rx_clk); det_frame = 1'b0;
      t_clear();
   endtask

   initial begin
      repeat (3) @(negedge rx_clk);
      bus_rst_n = 1'b1; rx_rst_n = 1'b1;
      @(negedge bus_clk);
      t_reset();
      t_enables();
      t_frame_set();
      t_clear();
      t_magic();
      t_disabled();
      t_irq_gate();
      t_clear();
      t_busy_ignore();
      write_ctrl(3'b111);
      t_set_wins();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge bus_clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule